// File: doc/BRIEF.md
# Train Start/Stop Command Serializer

This block drives one serial fast-command line, clocked at 100 MHz and fanned out to front-end electronics, with the commands that frame a particle train. A start command carries the 3-bit code `110`. It is followed directly by a 64-bit train number, a 16-bit bunch-structure word and one even-parity bit, all sent most significant bit first. A separate stop command carries the 3-bit code `101`. When nothing is being sent, the line rests at 0.

A host load strobe writes three shadow registers: the train number, the bunch-structure word and a lead time counted in 200 ns steps (20 line clocks each). The timing logic pulses a train-reference strobe a fixed `ARRIVAL_STEPS` steps before the train arrives. The block then waits until `lead` steps remain before arrival and launches the start command at that point.

A train-end request from the timing logic sends the stop command. If a stop request comes while a start command is still waiting or shifting, it is held and the stop code follows the last start-command bit with no gap. Frame contents are taken from the shadow registers in the cycle the start command is launched. A load made after that point therefore applies to the next train.

Top module: `tsc_train_cmd_ser`

## Requirements
- R1: After reset, and whenever no command bit is being sent, `ser_out` is 0 and `busy` is 0.
- R2: A start command is `FRAME_W` contiguous bits, most significant first: `1,1,0`, then train number bit 63 down to 0, then bunch word bit 15 down to 0, then a parity bit equal to the XOR of those 80 data bits (even parity).
- R3: If `train_ref` is high at clock edge k, the first start bit is on `ser_out` after edge k+1+D. D = (ARRIVAL_STEPS − lead) × CYC_PER_STEP, and D = 0 when lead ≥ ARRIVAL_STEPS. `lead` is the value held before edge k.
- R4: A `stop_req` sampled while the block is idle puts the bits `1,0,1` on `ser_out` starting after the next edge, after which the line returns to idle.
- R5: A `stop_req` sampled while a start command waits for launch or is shifting is held. The bits `1,0,1` then follow the last parity bit in the very next cycles.
- R6: Train number, bunch word and lead captured by `load_en` during a transmission do not alter that transmission. They are used by the next start command.
- R7: `busy` is 1 in exactly those cycles in which a command bit (start or stop) is on `ser_out`, including during the gap-free start-to-stop hand-over.
- R8: `train_ref` is ignored unless the block is idle. `stop_req` is ignored while a stop code is being sent.
- R9: A start command occupies the line for exactly `FRAME_W` (84 by default) cycles. The parameters are checked at elaboration so that this stays within 86 cycles (860 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Host strobe that writes the three shadow registers |
| train_id_in | input | ID_W | Train number to load |
| bunch_in | input | BS_W | Bunch-structure word to load |
| lead_in | input | LEAD_W | Lead time to load, in 200 ns steps |
| train_ref | input | 1 | Reference strobe, ARRIVAL_STEPS steps before train arrival |
| stop_req | input | 1 | Train-end request |
| ser_out | output | 1 | Serial fast-command line |
| busy | output | 1 | High while a command bit is on the line |

## Verification
The hardest case to reach is a stop request that arrives while a start command is still pending or shifting. In that case the stop code has to join the parity bit with no gap, so the stop must be released in the exact cycle the frame ends. The bench reaches this by timing stop pulses against the observed rise of `busy`: once during the lead wait and once in the middle of a frame. Host loads are placed in the middle of a frame in the same way, to show that the running frame keeps its captured values. A reference model built from queues follows the line bit by bit on every clock, so every gap, extra bit or misplaced parity bit is caught where it happens.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int          CODE_W     = 3;
   localparam logic [2:0]  START_CODE = 3'b110;
   localparam logic [2:0]  STOP_CODE  = 3'b101;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_FRAME = 2'd2,
      ST_STOP  = 2'd3
   } tsc_state_e;
endpackage

// File: rtl/tsc_lead_timer.sv
// Counts down the gap between the train reference and the start launch.
module tsc_lead_timer #(
   parameter int LEAD_W        = 16,
   parameter int CYC_PER_STEP  = 20,
   parameter int ARRIVAL_STEPS = 80000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [LEAD_W-1:0] lead_steps,
   output logic              fire
);
   localparam longint MAX_WAIT = longint'(ARRIVAL_STEPS) * longint'(CYC_PER_STEP);
   localparam int     CNT_W    = $clog2(MAX_WAIT + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] delay;
   logic             armed_q;
   logic [31:0]      lead_ext;

   always_comb begin
      lead_ext = 32'(lead_steps);
      if (lead_ext >= 32'(ARRIVAL_STEPS))
         delay = '0;
      else
         delay = CNT_W'((32'(ARRIVAL_STEPS) - lead_ext) * 32'(CYC_PER_STEP));
   end

   assign fire = armed_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm) begin
         armed_q <= 1'b1;
         cnt_q   <= delay;
      end else if (armed_q) begin
         if (cnt_q == '0)
            armed_q <= 1'b0;
         else
            cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/tsc_frame_build.sv
// Assembles the start-command word; a parameter selects the parity variant.
module tsc_frame_build #(
   parameter int ID_W      = 64,
   parameter int BS_W      = 16,
   parameter bit PARITY_EN = 1'b1,
   parameter int FRAME_W   = 3 + ID_W + BS_W + (PARITY_EN ? 1 : 0)
) (
   input  logic [ID_W-1:0]    train_id,
   input  logic [BS_W-1:0]    bunch,
   output logic [FRAME_W-1:0] frame
);
   import tsc_pkg::*;

   generate
      if (PARITY_EN) begin : g_par
         logic par_bit;
         assign par_bit = ^{train_id, bunch};
         assign frame   = {START_CODE, train_id, bunch, par_bit};
      end else begin : g_nopar
         assign frame = {START_CODE, train_id, bunch};
      end
   endgenerate
endmodule

// File: rtl/tsc_shifter.sv
// MSB-first parallel-to-serial shifter with a variable bit count.
module tsc_shifter #(
   parameter int W     = 84,
   parameter int LEN_W = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [W-1:0]     load_word,
   input  logic [LEN_W-1:0] load_len,
   output logic             line_q,
   output logic             active_q,
   output logic             last
);
   logic [W-1:0]     sreg_q;
   logic [LEN_W-1:0] rem_q;

   assign last = active_q && (rem_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q   <= 1'b0;
         active_q <= 1'b0;
         sreg_q   <= '0;
         rem_q    <= '0;
      end else if (load) begin
         line_q   <= load_word[W-1];
         sreg_q   <= {load_word[W-2:0], 1'b0};
         rem_q    <= load_len - LEN_W'(1);
         active_q <= 1'b1;
      end else if (active_q) begin
         if (rem_q == '0) begin
            active_q <= 1'b0;
            line_q   <= 1'b0;
         end else begin
            line_q <= sreg_q[W-1];
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            rem_q  <= rem_q - LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/tsc_train_cmd_ser.sv
module tsc_train_cmd_ser #(
   parameter int ID_W          = 64,
   parameter int BS_W          = 16,
   parameter int LEAD_W        = 16,
   parameter int CYC_PER_STEP  = 20,
   parameter int ARRIVAL_STEPS = 80000,
   parameter bit PARITY_EN     = 1'b1,
   parameter int MAX_FRAME_CYC = 86
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ID_W-1:0]   train_id_in,
   input  logic [BS_W-1:0]   bunch_in,
   input  logic [LEAD_W-1:0] lead_in,
   input  logic              train_ref,
   input  logic              stop_req,
   output logic              ser_out,
   output logic              busy
);
   import tsc_pkg::*;

   localparam int FRAME_W = CODE_W + ID_W + BS_W + (PARITY_EN ? 1 : 0);
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   generate
      if (ID_W < 1 || BS_W < 1)
         begin : g_bad_field $error("field widths must be positive"); end
      if (LEAD_W < 1 || LEAD_W > 32)
         begin : g_bad_lead $error("LEAD_W must be 1..32"); end
      if (CYC_PER_STEP < 1 || ARRIVAL_STEPS < 1)
         begin : g_bad_step $error("step timing must be positive"); end
      if (FRAME_W > MAX_FRAME_CYC)
         begin : g_too_long $error("start command exceeds its time budget"); end
   endgenerate

   logic [ID_W-1:0]    id_sh_q;
   logic [BS_W-1:0]    bs_sh_q;
   logic [LEAD_W-1:0]  lead_sh_q;
   tsc_state_e         state_q, state_d;
   logic               stop_pend_q, stop_pend_d;
   logic               arm, fire;
   logic               load_frame, load_stop, sh_load, sh_last;
   logic [FRAME_W-1:0] frame, sh_word;
   logic [LEN_W-1:0]   sh_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_sh_q   <= '0;
         bs_sh_q   <= '0;
         lead_sh_q <= '0;
      end else if (load_en) begin
         id_sh_q   <= train_id_in;
         bs_sh_q   <= bunch_in;
         lead_sh_q <= lead_in;
      end
   end

   tsc_frame_build #(
      .ID_W(ID_W), .BS_W(BS_W), .PARITY_EN(PARITY_EN), .FRAME_W(FRAME_W)
   ) u_build (
      .train_id(id_sh_q), .bunch(bs_sh_q), .frame(frame)
   );

   tsc_lead_timer #(
      .LEAD_W(LEAD_W), .CYC_PER_STEP(CYC_PER_STEP), .ARRIVAL_STEPS(ARRIVAL_STEPS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .arm(arm), .lead_steps(lead_sh_q), .fire(fire)
   );

   always_comb begin
      state_d     = state_q;
      stop_pend_d = stop_pend_q;
      arm         = 1'b0;
      load_frame  = 1'b0;
      load_stop   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (train_ref) begin
               arm         = 1'b1;
               stop_pend_d = stop_req;
               state_d     = ST_LEAD;
            end else if (stop_req) begin
               load_stop = 1'b1;
               state_d   = ST_STOP;
            end
         end
         ST_LEAD: begin
            if (stop_req) stop_pend_d = 1'b1;
            if (fire) begin
               load_frame = 1'b1;
               state_d    = ST_FRAME;
            end
         end
         ST_FRAME: begin
            if (sh_last) begin
               if (stop_pend_q || stop_req) begin
                  load_stop   = 1'b1;
                  stop_pend_d = 1'b0;
                  state_d     = ST_STOP;
               end else begin
                  state_d = ST_IDLE;
               end
            end else if (stop_req) begin
               stop_pend_d = 1'b1;
            end
         end
         ST_STOP: begin
            if (sh_last) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         stop_pend_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         stop_pend_q <= stop_pend_d;
      end
   end

   assign sh_load = load_frame | load_stop;
   assign sh_word = load_frame ? frame : {STOP_CODE, {(FRAME_W-CODE_W){1'b0}}};
   assign sh_len  = load_frame ? LEN_W'(FRAME_W) : LEN_W'(CODE_W);

   tsc_shifter #(.W(FRAME_W), .LEN_W(LEN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .load_word(sh_word),
      .load_len(sh_len), .line_q(ser_out), .active_q(busy), .last(sh_last)
   );
endmodule

// File: rtl/tsc_train_cmd_ser_chk.sv
module tsc_train_cmd_ser_chk
   import tsc_pkg::*;
#(
   parameter int FRAME_W = 84
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ser_out,
   input logic       busy,
   input logic       stop_req,
   input tsc_state_e st,
   input logic       sh_last,
   input logic       stop_pend
);
   logic [15:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      run_q <= '0;
      else if (st == ST_FRAME && busy) run_q <= run_q + 16'd1;
      else                             run_q <= '0;
   end

   // R9: a start command never holds the line longer than its length
   always @(posedge clk)
      if (rst_n) p_frame_len_r9: assert (run_q <= 16'(FRAME_W))
         else $error("frame longer than FRAME_W");

   p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ser_out);

   p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ser_out);

   p_quiet_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LEAD) |-> !busy);

   p_stop_joins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FRAME && sh_last && (stop_pend || stop_req))
      |=> (st == ST_STOP && busy && ser_out));

   p_busy_states_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_LEAD) |-> !busy);

   p_ref_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FRAME && !sh_last) |=> (st == ST_FRAME));
endmodule

bind tsc_train_cmd_ser tsc_train_cmd_ser_chk #(.FRAME_W(FRAME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_out(ser_out), .busy(busy),
   .stop_req(stop_req), .st(state_q), .sh_last(sh_last), .stop_pend(stop_pend_q)
);

// File: tb/tsc_train_cmd_ser_tb.sv
module tsc_train_cmd_ser_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ARR = 6;
   localparam int CPS = 20;
   localparam int FW  = 84;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_en = 1'b0;
   logic [63:0] id_in = '0;
   logic [15:0] bs_in = '0;
   logic [7:0]  lead_in = '0;
   logic        train_ref = 1'b0;
   logic        stop_req = 1'b0;
   logic        ser_out, busy;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tsc_train_cmd_ser #(
      .ID_W(64), .BS_W(16), .LEAD_W(8), .CYC_PER_STEP(CPS),
      .ARRIVAL_STEPS(ARR), .PARITY_EN(1'b1), .MAX_FRAME_CYC(86)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .train_id_in(id_in),
      .bunch_in(bs_in), .lead_in(lead_in), .train_ref(train_ref),
      .stop_req(stop_req), .ser_out(ser_out), .busy(busy)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_frame(input logic [63:0] id, input logic [15:0] bs);
      int ones = 0;
      for (int i = 0; i < 64; i++) ones += int'(id[i]);
      for (int i = 0; i < 16; i++) ones += int'(bs[i]);
      return {44'd0, 3'b110, id, bs, 1'(ones % 2)};
   endfunction

   // ---------------- behavioural reference model ----------------
   int          m_mode = 0;
   int          m_wait = 0;
   bit          m_pend = 0;
   bit          m_q[$];
   logic [63:0] m_id = '0;
   logic [15:0] m_bs = '0;
   int          m_lead = 0;
   logic        m_line = 0, m_busy = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_wait = 0; m_pend = 0; m_q.delete();
         m_id = '0; m_bs = '0; m_lead = 0; m_line = 0; m_busy = 0;
      end else begin
         case (m_mode)
            0: if (train_ref) begin
                  m_mode = 1;
                  m_wait = (m_lead >= ARR) ? 0 : (ARR - m_lead) * CPS;
                  if (stop_req) m_pend = 1;
               end else if (stop_req) begin
                  m_q = '{1'b1, 1'b0, 1'b1};
                  m_mode = 3;
               end
            1: begin
                  if (stop_req) m_pend = 1;
                  if (m_wait == 0) begin
                     logic [127:0] f;
                     f = exp_frame(m_id, m_bs);
                     for (int i = FW - 1; i >= 0; i--) m_q.push_back(f[i]);
                     m_mode = 2;
                  end else m_wait--;
               end
            2: if (m_q.size() == 0) begin
                  if (m_pend || stop_req) begin
                     m_q = '{1'b1, 1'b0, 1'b1};
                     m_mode = 3; m_pend = 0;
                  end else m_mode = 0;
               end else if (stop_req) m_pend = 1;
            default: if (m_q.size() == 0) m_mode = 0;
         endcase
         if (load_en) begin m_id = id_in; m_bs = bs_in; m_lead = int'(lead_in); end
         if (m_q.size() > 0) begin m_line = m_q.pop_front(); m_busy = 1; end
         else begin m_line = 0; m_busy = 0; end
      end
   end

   always @(negedge clk) if (rst_n && !finished) begin
      chk("R1/R2 line vs model", 128'(ser_out), 128'(m_line));
      chk("R7 busy vs model", 128'(busy), 128'(m_busy));
   end

   // ---------------- stimulus helpers ----------------
   task automatic do_load(input logic [63:0] id, input logic [15:0] bs, input logic [7:0] ld);
      @(negedge clk); load_en = 1; id_in = id; bs_in = bs; lead_in = ld;
      @(negedge clk); load_en = 0;
   endtask
   task automatic pulse_ref();
      @(negedge clk); train_ref = 1;
      @(negedge clk); train_ref = 0;
   endtask
   task automatic pulse_stop();
      @(negedge clk); stop_req = 1;
      @(negedge clk); stop_req = 0;
   endtask
   task automatic wait_busy(output int n);
      n = 0;
      while (!busy && n < 2000) begin @(negedge clk); n++; end
   endtask
   task automatic get_bits(input int n, output logic [127:0] v);
      v = '0;
      for (int i = 0; i < n; i++) begin
         v = {v[126:0], ser_out};
         if (i < n - 1) @(negedge clk);
      end
   endtask

   initial begin
      int n;
      logic [127:0] v, e;
      logic [63:0] ida, idb;
      ida = 64'h0123_4567_89AB_CDEF;
      idb = 64'hFEED_0000_1234_5678;

      repeat (3) @(negedge clk);
      chk("R1 reset line", 128'(ser_out), 128'd0);
      chk("R1 reset busy", 128'(busy), 128'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3 delayed launch, R2 frame contents, R9 length
      do_load(ida, 16'hA5C3, 8'd4);
      pulse_ref();
      wait_busy(n);
      chk("R3 launch delay lead=4", 128'(n), 128'((ARR - 4) * CPS + 1));
      get_bits(FW, v);
      chk("R2 frame lead=4", v, exp_frame(ida, 16'hA5C3));
      @(negedge clk);
      chk("R9 line idle after 84 bits", 128'(busy), 128'd0);

      // R3 clamp when lead exceeds arrival distance; R2 odd-parity data
      do_load('1, 16'h0001, 8'd9);
      pulse_ref();
      wait_busy(n);
      chk("R3 launch delay clamped", 128'(n), 128'd1);
      get_bits(FW, v);
      chk("R2 frame all-ones id", v, exp_frame('1, 16'h0001));
      @(negedge clk);

      // R4 stop from idle
      pulse_stop();
      get_bits(3, v);
      chk("R4 stop code", v, 128'b101);
      @(negedge clk);
      chk("R4 idle after stop", 128'(busy), 128'd0);

      // R5 stop during lead wait
      do_load(ida, 16'h1357, 8'd5);
      pulse_ref();
      repeat (5) @(negedge clk);
      pulse_stop();
      wait_busy(n);
      get_bits(FW + 3, v);
      e = exp_frame(ida, 16'h1357);
      chk("R5 stop held through wait", v, {e[124:0], 3'b101});
      @(negedge clk);
      chk("R5 idle after joined stop", 128'(busy), 128'd0);

      // R5 stop during frame
      do_load(idb, 16'h00F0, 8'd9);
      pulse_ref();
      wait_busy(n);
      pulse_stop();
      get_bits(FW + 1, v);
      e = exp_frame(idb, 16'h00F0);
      chk("R5 stop held through frame", v, {45'd0, e[81:0], 3'b101});
      @(negedge clk);

      // R6 load during frame keeps old values, applies to next
      do_load(ida, 16'h2222, 8'd9);
      pulse_ref();
      wait_busy(n);
      do_load(idb, 16'h3333, 8'd9);
      get_bits(FW - 2, v);
      e = exp_frame(ida, 16'h2222);
      chk("R6 running frame unchanged", v, {46'd0, e[81:0]});
      @(negedge clk);
      pulse_ref();
      wait_busy(n);
      get_bits(FW, v);
      chk("R6 next frame uses new load", v, exp_frame(idb, 16'h3333));
      @(negedge clk);

      // R8 reference during frame ignored
      pulse_ref();
      wait_busy(n);
      pulse_ref();
      repeat (FW - 1) @(negedge clk);
      n = 0;
      for (int i = 0; i < 200; i++) begin n += int'(busy); @(negedge clk); end
      chk("R8 ref during frame ignored", 128'(n), 128'd0);

      // R8 stop during stop code ignored
      pulse_stop();
      pulse_stop();
      @(negedge clk);
      n = 0;
      for (int i = 0; i < 10; i++) begin n += int'(busy); @(negedge clk); end
      chk("R8 stop during stop ignored", 128'(n), 128'd0);

      // R7 busy stays low during a long wait
      do_load(ida, 16'h0F0F, 8'd0);
      pulse_ref();
      n = 0;
      for (int i = 0; i < 100; i++) begin n += int'(busy); @(negedge clk); end
      chk("R7 busy low while waiting", 128'(n), 128'd0);
      wait_busy(n);
      get_bits(FW, v);
      chk("R2 frame after lead=0", v, exp_frame(ida, 16'h0F0F));
      repeat (3) @(negedge clk);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule